// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 12-bit successive-approximation converter. It runs on the master clock and decides when the analog front end tracks the input, when it may power down, and which trial code the external DAC presents to the comparator. It then resolves the result one bit per cycle from the comparator decision. The result is encoded either as offset binary or as modified sign-magnitude and held on a latched output bus. A busy flag and its complement mark the span of each conversion.

Every conversion frame lasts 20 clock cycles, counted from the clock edge that starts it to the edge that starts the next back-to-back frame. The frame is made of 5 tracking cycles, 12 bit-trial cycles, one encode cycle, one latch cycle and one finish cycle. The busy flag is low during the finish cycle, so the new result is already on the bus when busy falls. Holding the start request high with power-down disabled chains frames with no idle cycles between them. A single-cycle request gives one-shot operation. With the self power-down select high, the block drops into power-down once a frame has ended. A later request then wakes it, and the front end gets 5 settling cycles before tracking begins.

States and transitions of the controller:

- IDLE goes to TRACK on a request. Without a request, it goes to PDOWN when power-down is selected.
- PDOWN goes to WAKE on a request.
- WAKE goes to TRACK after 5 cycles.
- TRACK goes to TRIAL after 5 cycles.
- TRIAL goes to ENC after 12 cycles.
- ENC goes to LATCH, and LATCH goes to FIN.
- FIN goes to PDOWN when power-down is selected. Otherwise it goes to TRACK on a request, and to IDLE without one.
- The asynchronous reset forces IDLE from any state.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is high, the outputs are: dout = 0, busy = 0, busy_n = 1, track_en = 0, pwr_dn = 0.
- R2: In IDLE or FIN with pd_sel low, conv_req sampled high at a rising edge makes busy high from that edge onward. busy_n is always the inverse of busy.
- R3: A frame started from an active state keeps busy high for 19 cycles and then low for one finish cycle. track_en is high for exactly the first 5 of those busy cycles.
- R4: The first trial code after tracking is 1000_0000_0000. Each trial cycle keeps or clears the current bit from cmp_hi (1 = input at or above the trial code) and sets the next lower bit. The resolved raw code therefore equals the largest code not above the input.
- R5: With conv_req held high and pd_sel low, the next frame starts at the edge that ends the finish cycle, leaving exactly one low cycle of busy between frames.
- R6: In one-shot mode with pd_sel low, the block waits in IDLE with pwr_dn low and starts a new frame at the first edge at which a request is sampled.
- R7: pwr_dn is never high while busy is high. With pd_sel high, pwr_dn rises one cycle after the finish cycle.
- R8: A request sampled in power-down clears pwr_dn and gives 5 wake cycles with busy high and track_en low, followed by a normal frame, so busy stays high for 24 cycles.
- R9: With fmt_sm = 0, dout is the raw code in offset binary: mid-scale 1000_0000_0000 is zero, and dout[11] is the MSB.
- R10: With fmt_sm = 1, a raw code with MSB set gives dout = {0, raw[10:0]}. A raw code with MSB clear gives dout = {1, ~raw[10:0]}. So raw 0x7FF gives 0x800 and raw 0x000 gives 0xFFF.
- R11: dout holds its value throughout a conversion and changes only at the edge where busy falls.
- R12: Raising reset in the middle of a frame drops busy and clears dout at once, without waiting for a clock edge, and aborts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| conv_req | input | 1 | Start request, sampled on rising edges |
| pd_sel | input | 1 | Self power-down select |
| fmt_sm | input | 1 | Output format: 0 offset binary, 1 modified sign-magnitude |
| cmp_hi | input | 1 | Comparator decision: input at or above the trial code |
| trial_code | output | 12 | Code driven to the external DAC |
| track_en | output | 1 | Track/sample enable for the front end |
| pwr_dn | output | 1 | Power-down enable for the analog side |
| busy | output | 1 | Conversion in progress |
| busy_n | output | 1 | Inverse of busy |
| dout | output | 12 | Latched conversion result |

## Verification
A wrong state or counter value shows up at the ports within one frame. It appears as a busy span other than 19 or 24 cycles, a track window other than 5 cycles, or pwr_dn rising while busy. A fault in the trial register or the encoder corrupts dout at the very next busy fall, so the bench compares every finished frame against codes worked out from the input and the format bit. Back-to-back frames and the wake path are timed cycle by cycle at the ports.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PDOWN,
        ST_WAKE,
        ST_TRACK,
        ST_TRIAL,
        ST_ENC,
        ST_LATCH,
        ST_FIN
    } sar_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sar_fsm.sv
`timescale 1ns/1ps
module sar_fsm
    import sar_pkg::*;
#(
    parameter int NBITS     = 12,
    parameter int TRACK_CYC = 5,
    parameter int WAKE_CYC  = 5,
    parameter int CW        = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_req,
    input  logic          pd_sel,
    output logic [CW-1:0] cnt,
    output logic          busy,
    output logic          track_en,
    output logic          pwr_dn,
    output logic          trial_load,
    output logic          trial_step,
    output logic          enc_en,
    output logic          latch_en
);

    sar_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (conv_req)    state_d = ST_TRACK;
                else if (pd_sel) state_d = ST_PDOWN;
            end
            ST_PDOWN: begin
                if (conv_req) state_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (cnt_q == CW'(WAKE_CYC - 1)) state_d = ST_TRACK;
            end
            ST_TRACK: begin
                if (cnt_q == CW'(TRACK_CYC - 1)) state_d = ST_TRIAL;
            end
            ST_TRIAL: begin
                if (cnt_q == CW'(NBITS - 1)) state_d = ST_ENC;
            end
            ST_ENC:   state_d = ST_LATCH;
            ST_LATCH: state_d = ST_FIN;
            ST_FIN: begin
                if (pd_sel)        state_d = ST_PDOWN;
                else if (conv_req) state_d = ST_TRACK;
                else               state_d = ST_IDLE;
            end
        endcase
    end

    // state register and in-state cycle counter
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + CW'(1);
        end
    end

    // Moore outputs
    always_comb begin
        busy       = 1'b0;
        track_en   = 1'b0;
        pwr_dn     = 1'b0;
        trial_step = 1'b0;
        enc_en     = 1'b0;
        latch_en   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PDOWN: pwr_dn = 1'b1;
            ST_WAKE:  busy = 1'b1;
            ST_TRACK: begin
                busy     = 1'b1;
                track_en = 1'b1;
            end
            ST_TRIAL: begin
                busy       = 1'b1;
                trial_step = 1'b1;
            end
            ST_ENC: begin
                busy   = 1'b1;
                enc_en = 1'b1;
            end
            ST_LATCH: begin
                busy     = 1'b1;
                latch_en = 1'b1;
            end
            ST_FIN:   ;
        endcase
    end

    assign trial_load = (state_q == ST_TRACK) && (state_d == ST_TRIAL);
    assign cnt        = cnt_q;

endmodule

// File: rtl/sar_trial.sv
`timescale 1ns/1ps
module sar_trial #(
    parameter int NBITS = 12,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [CW-1:0]    cnt,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] code
);

    logic [NBITS-1:0] code_q;
    logic [CW-1:0]    bidx;

    // bit under trial, MSB first
    assign bidx = CW'(NBITS - 1) - cnt;

    for (genvar gi = 0; gi < NBITS; gi++) begin : g_bit
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                code_q[gi] <= 1'b0;
            end else if (load) begin
                code_q[gi] <= (gi == NBITS - 1);
            end else if (step) begin
                if (bidx == CW'(gi))
                    code_q[gi] <= cmp_hi;
                else if (bidx == CW'(gi + 1))
                    code_q[gi] <= 1'b1;
            end
        end
    end

    assign code = code_q;

endmodule

// File: rtl/sar_encode.sv
`timescale 1ns/1ps
module sar_encode #(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc_en,
    input  logic             latch_en,
    input  logic             fmt_sm,
    input  logic [NBITS-1:0] raw,
    output logic [NBITS-1:0] dout
);

    logic [NBITS-1:0] sm_code;
    logic [NBITS-1:0] res_q;
    logic [NBITS-1:0] dout_q;

    // modified sign-magnitude: upper half keeps magnitude, lower half is mirrored
    assign sm_code = raw[NBITS-1] ? {1'b0, raw[NBITS-2:0]}
                                  : {1'b1, ~raw[NBITS-2:0]};

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            res_q  <= '0;
            dout_q <= '0;
        end else begin
            if (enc_en)   res_q  <= fmt_sm ? sm_code : raw;
            if (latch_en) dout_q <= res_q;
        end
    end

    assign dout = dout_q;

endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl #(
    parameter int NBITS     = 12,
    parameter int TRACK_CYC = 5,
    parameter int WAKE_CYC  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_req,
    input  logic             pd_sel,
    input  logic             fmt_sm,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] trial_code,
    output logic             track_en,
    output logic             pwr_dn,
    output logic             busy,
    output logic             busy_n,
    output logic [NBITS-1:0] dout
);

    localparam int CNT_MAX = sar_pkg::max3(NBITS, TRACK_CYC, WAKE_CYC);
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic [CW-1:0] cnt;
    logic          trial_load;
    logic          trial_step;
    logic          enc_en;
    logic          latch_en;
    logic          busy_i;

    sar_fsm #(
        .NBITS    (NBITS),
        .TRACK_CYC(TRACK_CYC),
        .WAKE_CYC (WAKE_CYC),
        .CW       (CW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .conv_req  (conv_req),
        .pd_sel    (pd_sel),
        .cnt       (cnt),
        .busy      (busy_i),
        .track_en  (track_en),
        .pwr_dn    (pwr_dn),
        .trial_load(trial_load),
        .trial_step(trial_step),
        .enc_en    (enc_en),
        .latch_en  (latch_en)
    );

    sar_trial #(
        .NBITS(NBITS),
        .CW   (CW)
    ) u_trial (
        .clk   (clk),
        .rst   (rst),
        .load  (trial_load),
        .step  (trial_step),
        .cnt   (cnt),
        .cmp_hi(cmp_hi),
        .code  (trial_code)
    );

    sar_encode #(
        .NBITS(NBITS)
    ) u_enc (
        .clk     (clk),
        .rst     (rst),
        .enc_en  (enc_en),
        .latch_en(latch_en),
        .fmt_sm  (fmt_sm),
        .raw     (trial_code),
        .dout    (dout)
    );

    assign busy   = busy_i;
    assign busy_n = ~busy_i;

endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
    parameter int NBITS = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             conv_req,
    input logic             pd_sel,
    input logic [NBITS-1:0] trial_code,
    input logic             track_en,
    input logic             pwr_dn,
    input logic             busy,
    input logic [NBITS-1:0] dout
);

    localparam logic [NBITS-1:0] MID = {1'b1, {(NBITS-1){1'b0}}};

    // R7
    a_r7_no_pd_while_busy: assert property (@(posedge clk) disable iff (rst)
        !(pwr_dn && busy));

    // R7
    a_r7_pd_after_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_dn) |-> $past(!busy));

    // R11
    a_r11_dout_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(dout));

    // R4
    a_r4_first_trial: assert property (@(posedge clk) disable iff (rst)
        $fell(track_en) |-> (trial_code == MID));

    // R3
    a_r3_track_then_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(track_en) |-> busy);

    // R5
    a_r5_back_to_back: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && conv_req && !pd_sel) |=> busy);

    // R8
    a_r8_wake_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_dn) |-> (busy && !track_en));

    // R2
    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && !pwr_dn && conv_req && !pd_sel) |=> busy);

endmodule

bind sar_seq_ctrl sar_seq_chk #(.NBITS(NBITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .conv_req  (conv_req),
    .pd_sel    (pd_sel),
    .trial_code(trial_code),
    .track_en  (track_en),
    .pwr_dn    (pwr_dn),
    .busy      (busy),
    .dout      (dout)
);

// File: tb/tb_sar_seq_ctrl.sv
`timescale 1ns/1ps
module tb_sar_seq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_req = 1'b0;
    logic        pd_sel = 1'b0;
    logic        fmt_sm = 1'b0;
    logic        cmp_hi;
    logic [11:0] vin = 12'h000;
    logic [11:0] trial_code;
    logic        track_en, pwr_dn, busy, busy_n;
    logic [11:0] dout;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // comparator model of the analog side
    assign cmp_hi = (vin >= trial_code);

    sar_seq_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .conv_req  (conv_req),
        .pd_sel    (pd_sel),
        .fmt_sm    (fmt_sm),
        .cmp_hi    (cmp_hi),
        .trial_code(trial_code),
        .track_en  (track_en),
        .pwr_dn    (pwr_dn),
        .busy      (busy),
        .busy_n    (busy_n),
        .dout      (dout)
    );

    // {fmt, input code, expected dout}
    localparam logic [24:0] VEC [8] = '{
        {1'b0, 12'h000, 12'h000},
        {1'b0, 12'hFFF, 12'hFFF},
        {1'b0, 12'hA5C, 12'hA5C},
        {1'b1, 12'h800, 12'h000},
        {1'b1, 12'h7FF, 12'h800},
        {1'b1, 12'h000, 12'hFFF},
        {1'b1, 12'hFFF, 12'h7FF},
        {1'b1, 12'h3A1, 12'hC5E}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // one request pulse, then measure the busy span and the result
    task automatic frame(input logic [11:0] v, input logic f, input logic pd,
                         input logic [11:0] exp, input int exp_busy, input string req);
        logic [11:0] prev;
        int bc, tc;
        logic hold_bad, pd_bad, inv_bad;
        @(negedge clk);
        vin = v; fmt_sm = f; pd_sel = pd; conv_req = 1'b1;
        prev = dout;
        @(negedge clk);
        conv_req = 1'b0;
        bc = 0; tc = 0; hold_bad = 0; pd_bad = 0; inv_bad = 0;
        while (busy && bc < 100) begin
            bc++;
            if (track_en) tc++;
            if (dout !== prev) hold_bad = 1;
            if (pwr_dn) pd_bad = 1;
            if (busy_n !== ~busy) inv_bad = 1;
            @(negedge clk);
        end
        check(req, "busy span", bc, exp_busy);
        check("R3", "track cycles", tc, 5);
        check(req, "dout", dout, exp);
        check("R11", "dout held while busy", hold_bad, 0);
        check("R7", "pwr_dn while busy", pd_bad, 0);
        check("R2", "busy_n inverse", inv_bad, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        check("R1", "dout", dout, 0);
        check("R1", "busy", busy, 0);
        check("R1", "busy_n", busy_n, 1);
        check("R1", "track_en", track_en, 0);
        check("R1", "pwr_dn", pwr_dn, 0);
        rst = 1'b0;
        @(negedge clk);

        // R9 / R10 / R4 vector table, one-shot frames
        for (int i = 0; i < 8; i++) begin
            frame(VEC[i][23:12], VEC[i][24], 1'b0, VEC[i][11:0], 19,
                  VEC[i][24] ? "R10" : "R9");
        end

        // R5 continuous conversion
        @(negedge clk);
        vin = 12'h123; fmt_sm = 1'b0; conv_req = 1'b1;
        @(negedge clk);
        begin
            int bc;
            bc = 0;
            while (busy && bc < 100) begin bc++; @(negedge clk); end
            check("R5", "first span", bc, 19);
            check("R4", "first result", dout, 12'h123);
            vin = 12'h456;
            @(negedge clk);
            check("R5", "restart after one idle", busy, 1);
            bc = 0;
            while (busy && bc < 100) begin bc++; @(negedge clk); end
            check("R5", "second span", bc, 19);
            check("R5", "second result", dout, 12'h456);
            conv_req = 1'b0;
        end

        // R6 one-shot idle then immediate restart
        repeat (3) @(negedge clk);
        check("R6", "idle busy", busy, 0);
        check("R6", "idle pwr_dn", pwr_dn, 0);
        frame(12'h0F0, 1'b0, 1'b0, 12'h0F0, 19, "R6");

        // R7 self power-down after frame
        frame(12'h321, 1'b0, 1'b1, 12'h321, 19, "R7");
        check("R7", "pwr_dn in finish cycle", pwr_dn, 0);
        @(negedge clk);
        check("R7", "pwr_dn after frame", pwr_dn, 1);
        repeat (4) @(negedge clk);
        check("R7", "stays down without request", pwr_dn, 1);
        check("R7", "no busy while down", busy, 0);

        // R8 wake from power-down
        frame(12'h9AB, 1'b1, 1'b1, 12'h1AB, 24, "R8");
        @(negedge clk);
        check("R8", "back to power-down", pwr_dn, 1);
        pd_sel = 1'b0;
        repeat (2) @(negedge clk);
        check("R8", "pd_sel low alone does not wake", pwr_dn, 1);
        frame(12'h6C3, 1'b0, 1'b0, 12'h6C3, 24, "R8");
        @(negedge clk);
        check("R8", "idle after wake frame", pwr_dn, 0);

        // R12 async reset mid-frame
        vin = 12'h5A5; conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        repeat (7) @(negedge clk);
        #2 rst = 1'b1;
        #1;
        check("R12", "busy cleared", busy, 0);
        check("R12", "busy_n set", busy_n, 1);
        check("R12", "dout cleared", dout, 0);
        check("R12", "track_en cleared", track_en, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12", "frame aborted", busy, 0);
        frame(12'h5A5, 1'b0, 1'b0, 12'h5A5, 19, "R12");

        finish_run();
    end

endmodule